// File: doc/BRIEF.md
# Masked Ethernet Destination Address Filter

This block decides, one lookup per clock, whether a received frame's 48-bit destination address is accepted. The address is compared against a bank of programmable station entries. Each entry has its own address, a per-bit don't-care mask and an enable bit. A multicast address can also be accepted through a 256-bit hash bitmap. The bitmap is indexed by eight bits of an Ethernet CRC-32 taken over the address.

Configuration arrives on a simple register-write port that selects entry addresses, entry masks, the control word and the hash words. Lookups are strobed with `da_valid`. The accept decision is registered and appears one clock later on `res_match`, qualified by `res_valid`.

Top module: `da_filter`

## Requirements
- R1: After reset, every entry is disabled, the hash path is off and the hash bitmap is all zero. `res_valid` and `res_match` are 0, and no lookup matches until the block is configured.
- R2: An enabled entry i matches when `(da & ~mask_i) == (addr_i & ~mask_i)`. A mask bit of 1 makes that address bit a don't-care.
- R3: Bit i of the enable field (bit 0 for entry 0) gates entry i. A disabled entry never matches, whatever its address and mask.
- R4: Address bit order: for an address written aa-bb-cc-dd-ee-ff, `da[47:40]` and the stored entry bits 47:40 hold aa, and `da[7:0]` holds ff.
- R5: The hash index is computed as follows. Run the reflected CRC-32 (polynomial 0xEDB88320) with the register preset to 0xFFFFFFFF. Feed the bytes aa first and ff last, each byte LSB first, with no final inversion. The index is bits 31:24 of the final register.
- R6: The hash path can only contribute to a match when the group bit `da[40]` is 1.
- R7: The hash path can only contribute to a match when the hash enable bit is 1.
- R8: Hash word w holds bitmap bits 16w+15 down to 16w. The hash hit is the bitmap bit at the hash index.
- R9: `res_match` is the OR of all enabled entry matches and the gated hash hit.
- R10: `res_valid` is 1 exactly one clock after a cycle with `da_valid` = 1. `res_match` is only 1 when `res_valid` is 1.
- R11: The write port is used as follows. `wr_kind` 0 writes entry `wr_idx` address from `wr_data[47:0]`. Kind 1 writes entry `wr_idx` mask. Kind 2 writes the control word: enables from `wr_data[15:0]` and hash enable from `wr_data[16]`. Kind 3 writes hash word `wr_idx` from `wr_data[15:0]`. A write is used by lookups strobed in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 address, 1 mask, 2 control, 3 hash word |
| wr_idx | input | 4 | Entry or hash word index |
| wr_data | input | 48 | Write data |
| da_valid | input | 1 | Lookup strobe |
| da | input | 48 | Destination address to test |
| res_valid | output | 1 | Result valid, one clock after the strobe |
| res_match | output | 1 | Address accepted |

## Verification
The assertions take for granted that `wr_idx` stays within the entry and hash word counts. They also assume the control word is only written through kind 2, so the enable and hash enable bits stay stable otherwise. The stimulus draws indices only from the legal range. It never writes and looks up in the same cycle, so each expected value depends on a configuration that is already settled. Random lookups mix addresses near programmed entries, with flips limited to masked bits, and fully random and multicast addresses. This exercises both the entry and the hash contributions.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    typedef enum logic [1:0] {
        KIND_ADDR = 2'd0,
        KIND_MASK = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_HASH = 2'd3
    } wr_kind_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs #(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 48,
    parameter int TBL_W   = 256,
    parameter int HWORD_W = 16,
    parameter int IDX_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]             wr_data,
    output logic [N_ENTRY-1:0][ADDR_W-1:0] addr_o,
    output logic [N_ENTRY-1:0][ADDR_W-1:0] mask_o,
    output logic [N_ENTRY-1:0]            en_o,
    output logic                          hash_en_o,
    output logic [TBL_W-1:0]              table_o
);
    import dafilt_pkg::*;

    localparam int HWORDS = TBL_W / HWORD_W;

    typedef struct packed {
        logic [N_ENTRY-1:0][ADDR_W-1:0] addr;
        logic [N_ENTRY-1:0][ADDR_W-1:0] mask;
        logic [N_ENTRY-1:0]             en;
        logic                           hash_en;
        logic [HWORDS-1:0][HWORD_W-1:0] tbl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_kind_e'(wr_kind))
                KIND_ADDR: if (int'(wr_idx) < N_ENTRY) cfg_d.addr[wr_idx] = wr_data;
                KIND_MASK: if (int'(wr_idx) < N_ENTRY) cfg_d.mask[wr_idx] = wr_data;
                KIND_CTRL: begin
                    cfg_d.en      = wr_data[N_ENTRY-1:0];
                    cfg_d.hash_en = wr_data[N_ENTRY];
                end
                KIND_HASH: if (int'(wr_idx) < HWORDS) cfg_d.tbl[wr_idx] = wr_data[HWORD_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign addr_o    = cfg_q.addr;
    assign mask_o    = cfg_q.mask;
    assign en_o      = cfg_q.en;
    assign hash_en_o = cfg_q.hash_en;
    assign table_o   = cfg_q.tbl;

    // R11: a control write lands in the enable field on the next clock
    a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd2) |=> (en_o == $past(wr_data[N_ENTRY-1:0])
                                         && hash_en_o == $past(wr_data[N_ENTRY])));
    // R3: enables change only through a control write
    a_r3_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_kind == 2'd2) |=> ($stable(en_o) && $stable(hash_en_o)));
endmodule

// File: rtl/dafilt_cam.sv
module dafilt_cam #(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 48
) (
    input  logic [ADDR_W-1:0]              da,
    input  logic [N_ENTRY-1:0][ADDR_W-1:0] addr,
    input  logic [N_ENTRY-1:0][ADDR_W-1:0] mask,
    input  logic [N_ENTRY-1:0]             en,
    output logic [N_ENTRY-1:0]             hit
);
    for (genvar i = 0; i < N_ENTRY; i++) begin : g_entry
        logic [ADDR_W-1:0] diff;
        assign diff   = (da ^ addr[i]) & ~mask[i];
        assign hit[i] = en[i] && (diff == '0);
    end
endmodule

// File: rtl/dafilt_crc_idx.sv
module dafilt_crc_idx #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 8
) (
    input  logic [ADDR_W-1:0] da,
    output logic [HASH_W-1:0] idx
);
    import dafilt_pkg::*;

    localparam int NBYTES = ADDR_W / 8;

    logic [31:0] crc;

    always_comb begin
        crc = CRC_PRESET;
        for (int b = NBYTES - 1; b >= 0; b--) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb  = crc[0] ^ da[b*8 + k];
                crc = {1'b0, crc[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
            end
        end
        idx = crc[31 -: HASH_W];
    end
endmodule

// File: rtl/da_filter.sv
module da_filter #(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 48,
    parameter int HASH_W  = 8,
    parameter int HWORD_W = 16,
    localparam int TBL_W  = 1 << HASH_W,
    localparam int HWORDS = TBL_W / HWORD_W,
    localparam int IDX_W  = $clog2(N_ENTRY > HWORDS ? N_ENTRY : HWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    output logic              res_valid,
    output logic              res_match
);
    localparam int GROUP_BIT = ADDR_W - 8;

    logic [N_ENTRY-1:0][ADDR_W-1:0] addr_w, mask_w;
    logic [N_ENTRY-1:0]             en_w, hit_w;
    logic                           hash_en_w;
    logic [TBL_W-1:0]               table_w;
    logic [HASH_W-1:0]              hidx_w;
    logic                           hash_hit;

    dafilt_regs #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W), .TBL_W(TBL_W),
                  .HWORD_W(HWORD_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .addr_o(addr_w), .mask_o(mask_w),
        .en_o(en_w), .hash_en_o(hash_en_w), .table_o(table_w));

    dafilt_cam #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_cam (
        .da(da), .addr(addr_w), .mask(mask_w), .en(en_w), .hit(hit_w));

    dafilt_crc_idx #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_crc (
        .da(da), .idx(hidx_w));

    assign hash_hit = hash_en_w && da[GROUP_BIT] && table_w[hidx_w];

    typedef struct packed {
        logic valid;
        logic match;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.valid = da_valid;
        res_d.match = da_valid && ((|hit_w) || hash_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_match = res_q.match;

    // R10: result strobe follows lookup strobe by one clock
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);
    a_r10_match_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        res_match |-> res_valid);
    // R6: a unicast address with no entry hit cannot match
    a_r6_unicast_no_hash: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !da[GROUP_BIT] && hit_w == '0) |=> !res_match);
    // R7: with hashing off, only entry hits can match
    a_r7_hash_off: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !hash_en_w && hit_w == '0) |=> !res_match);
    // R3: with every entry disabled and the hash path closed, nothing matches
    a_r3_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && en_w == '0 && !(hash_en_w && da[GROUP_BIT])) |=> !res_match);
    // R9: any entry hit forces a match
    a_r9_entry_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && hit_w != '0) |=> res_match);
endmodule

// File: tb/tb_da_filter.sv
`timescale 1ns/1ps
module tb_da_filter;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [3:0]  wr_idx = '0;
    logic [47:0] wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_match;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [47:0] m_addr [N];
    logic [47:0] m_mask [N];
    logic [N-1:0] m_en;
    logic         m_hen;
    logic [255:0] m_tbl;

    da_filter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .da_valid(da_valid), .da(da),
        .res_valid(res_valid), .res_match(res_match));

    always #10 clk = ~clk;

    function automatic logic [7:0] hash_idx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int b = 5; b >= 0; b--)
            for (int k = 0; k < 8; k++) begin
                logic f;
                f = c[0] ^ a[b*8+k];
                c = (c >> 1) ^ (f ? 32'hEDB8_8320 : 32'h0);
            end
        return c[31:24];
    endfunction

    function automatic logic exp_match(input logic [47:0] a);
        logic m;
        m = m_hen && a[40] && m_tbl[hash_idx(a)];
        for (int i = 0; i < N; i++)
            if (m_en[i] && (((a ^ m_addr[i]) & ~m_mask[i]) == 48'h0)) m = 1'b1;
        return m;
    endfunction

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int idx, input logic [47:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (k)
            2'd0: m_addr[idx] = d;
            2'd1: m_mask[idx] = d;
            2'd2: begin m_en = d[N-1:0]; m_hen = d[N]; end
            default: m_tbl[idx*16 +: 16] = d[15:0];
        endcase
    endtask

    task automatic look(input logic [47:0] a, input string req);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        @(negedge clk);
        da_valid = 1'b0;
        check(res_valid, 1'b1, "R10 valid");
        check(res_match, exp_match(a), req);
    endtask

    task automatic clear_tbl();
        for (int w = 0; w < 16; w++) wr(2'd3, w, 48'h0);
    endtask

    initial begin
        logic [47:0] a, mc;
        logic [7:0]  hi;
        void'($urandom(32'h1BADF00D));
        for (int i = 0; i < N; i++) begin m_addr[i] = '0; m_mask[i] = '0; end
        m_en = '0; m_hen = 1'b0; m_tbl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(res_valid, 1'b0, "R1 reset valid");
        check(res_match, 1'b0, "R1 reset match");
        look(48'h0, "R1 zero address after reset");
        look(48'h01_00_5E_00_00_01, "R1 multicast after reset");
        @(negedge clk);
        check(res_valid, 1'b0, "R10 idle no valid");

        // R4/R2: exact entry, byte order aa at [47:40]
        wr(2'd0, 0, 48'h0A_0B_0C_0D_0E_0F);
        wr(2'd2, 0, 48'h1);
        look(48'h0A_0B_0C_0D_0E_0F, "R4 byte order exact match");
        look(48'h0F_0E_0D_0C_0B_0A, "R4 reversed bytes no match");
        // R2: mask low byte as don't-care
        wr(2'd1, 0, 48'h0000_0000_00FF);
        look(48'h0A_0B_0C_0D_0E_77, "R2 masked byte ignored");
        look(48'h0A_0B_0C_0D_1E_0F, "R2 unmasked bit differs");
        // R3: disabled entry never matches; entry 5 uses bit 5
        wr(2'd0, 5, 48'h1234_5678_9ABC);
        wr(2'd2, 0, 48'h0);
        look(48'h0A_0B_0C_0D_0E_0F, "R3 entry0 disabled");
        wr(2'd2, 0, 48'h20);
        look(48'h1234_5678_9ABC, "R3 entry5 enabled by bit5");
        wr(2'd2, 0, 48'h10);
        look(48'h1234_5678_9ABC, "R3 entry5 off with bit4");

        // hash path
        mc = 48'h01_00_5E_12_34_56;
        hi = hash_idx(mc);
        wr(2'd2, 0, 48'h0);
        wr(2'd3, hi / 16, 48'(16'(1) << (hi % 16)));
        look(mc, "R7 hash disabled");
        wr(2'd2, 0, 48'h1_0000);
        look(mc, "R5 R8 hash bit hit");
        a = mc & ~48'h01_00_00_00_00_00;
        if (m_tbl[hash_idx(a)] == 1'b0) wr(2'd3, hash_idx(a) / 16, 48'hFFFF);
        look(a, "R6 unicast ignores hash");
        clear_tbl();
        for (int w = 0; w < 16; w++) wr(2'd3, w, (w == hi / 16) ? 48'(~(16'(1) << (hi % 16))) : 48'hFFFF);
        look(mc, "R8 neighbour bits only no hit");
        clear_tbl();
        // R9: entry hit and hash both contribute
        wr(2'd0, 3, mc);
        wr(2'd2, 0, 48'h1_0008);
        look(mc, "R9 entry hit with empty table");

        // random
        for (int r = 0; r < 300; r++) begin
            if (r % 50 == 0) begin
                for (int i = 0; i < N; i++) begin
                    wr(2'd0, i, rnd48());
                    wr(2'd1, i, rnd48() & rnd48() & rnd48());
                end
                for (int w = 0; w < 16; w++) wr(2'd3, w, 48'($urandom() & $urandom()));
                wr(2'd2, 0, 48'($urandom() & 32'h1_FFFF));
            end
            case ($urandom_range(0, 2))
                0: a = rnd48();
                1: begin
                    int e;
                    e = $urandom_range(0, N-1);
                    a = m_addr[e] ^ (rnd48() & m_mask[e]);
                end
                default: a = rnd48() | 48'h01_00_00_00_00_00;
            endcase
            look(a, "R9 random lookup");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule